// File: doc/BRIEF.md
# Accumulator Arithmetic Unit with Status Word

This block is the arithmetic core of a small 8-bit controller. It holds an accumulator, a helper register and a status word. When the strobe `op_valid` is high, it runs one of five arithmetic operations in a single clock cycle:

- addition, with or without the stored carry;
- subtraction with borrow;
- unsigned multiply;
- unsigned divide.

For add and subtract, the second operand comes from the operand bus. Multiply and divide use the helper register as the second operand. Two load codes place the operand byte into either register, so that a sequencer can set up operands.

The status word holds the following bits:

- carry;
- half-carry, taken across the nibble boundary;
- overflow, which is shared by signed add/subtract overflow, a multiply product wider than a byte, and a zero divisor;
- two general-purpose flag bits;
- a two-bit bank selector;
- a parity bit that always follows the accumulator.

A direct write port loads every status bit except parity. When an arithmetic operation runs in the same cycle, the flags it produces override the written values. A combinational helper output joins the bank selector with a 3-bit working-register index to form a 5-bit internal RAM address.

Top module: `accu_alu_top`

## Requirements
- R1: While `rst` is high at a clock edge, the accumulator, the helper register and the whole status word become 0.
- R2: With `op_valid` high, code 0 (plain add) loads the accumulator with `(acc + operand) mod 256` and ignores the carry. Code 1 (add with carry) adds the stored carry as well. Carry (status bit 7) becomes 1 exactly when the unsigned sum exceeds 255.
- R3: Code 2 (subtract with borrow) loads the accumulator with `(acc - operand - carry) mod 256`. Carry becomes 1 exactly when that difference is negative.
- R4: For codes 0 to 2, half-carry (status bit 6) is set on a carry out of the low nibble (add) or a borrow into the low nibble (subtract), and is cleared otherwise. Codes 3 to 6 leave it unchanged.
- R5: For codes 0 to 2, overflow (status bit 2) is 1 exactly when the two's-complement result falls outside -128..127.
- R6: Code 3 (multiply) puts the low byte of `acc*helper` in the accumulator and the high byte in the helper register. It clears carry, and sets overflow exactly when the product exceeds 255.
- R7: Code 4 (divide) puts `acc/helper` in the accumulator and the remainder in the helper register, clears carry and clears overflow. With a zero helper register, both registers keep their values, carry is cleared and overflow is set.
- R8: Status bit 0 is 1 exactly when the accumulator holds an odd number of 1 bits, at every cycle. A direct write never alters it.
- R9: `ram_addr` equals `{status[4:3], reg_idx}`, so banks 0 to 3 cover 0x00-0x07, 0x08-0x0F, 0x10-0x17 and 0x18-0x1F.
- R10: With `psw_we` high, status bits 7:1 take `psw_wdata[7:1]` at the clock edge. When an arithmetic code runs in the same cycle, carry, overflow and (for codes 0 to 2) half-carry take the arithmetic values. Bits 5, 4:3 and 1 still come from the write.
- R11: Code 5 loads the accumulator from `operand`, and code 6 loads the helper register from `operand`. Neither changes carry, half-carry or overflow.
- R12: With `op_valid` low, or with code 7, the accumulator and the helper register keep their values. The status word also keeps its value unless `psw_we` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation strobe, one operation per cycle |
| op_code | input | 3 | 0 add, 1 add with carry, 2 subtract with borrow, 3 multiply, 4 divide, 5 load accumulator, 6 load helper, 7 no operation |
| operand | input | 8 | Second operand for add/subtract, data for loads |
| psw_we | input | 1 | Direct status word write enable |
| psw_wdata | input | 8 | Direct status word write data (bit 0 ignored) |
| reg_idx | input | 3 | Working-register index |
| acc_q | output | 8 | Accumulator |
| b_q | output | 8 | Helper register |
| psw_q | output | 8 | Status word: 7 carry, 6 half-carry, 5 flag A, 4:3 bank, 2 overflow, 1 flag B, 0 parity |
| ram_addr | output | 5 | Banked internal RAM address |

## Verification
Each operation or status write presented before a rising edge appears on `acc_q`, `b_q` and `psw_q` one edge later. This includes the parity bit, which is registered from the next accumulator value. The bench drives inputs just after a falling edge and samples at the next falling edge, so exactly one rising edge lies between stimulus and check. `ram_addr` has no latency: it is combinational from the registered bank field and `reg_idx`, and it is compared in the same sample against the bank the model expects after that edge.

// File: rtl/accu_pkg.sv
package accu_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_ADDC = 3'd1,
    OP_SUBB = 3'd2,
    OP_MUL  = 3'd3,
    OP_DIV  = 3'd4,
    OP_LDA  = 3'd5,
    OP_LDB  = 3'd6,
    OP_NOP  = 3'd7
  } accu_op_e;

  localparam int PSW_W     = 8;
  localparam int PSW_CY    = 7;
  localparam int PSW_AC    = 6;
  localparam int PSW_UA    = 5;
  localparam int PSW_RS_HI = 4;
  localparam int PSW_RS_LO = 3;
  localparam int PSW_OV    = 2;
  localparam int PSW_UB    = 1;
  localparam int PSW_PAR   = 0;
endpackage

// File: rtl/accu_addsub.sv
module accu_addsub #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          sub,
  input  logic          cin,
  output logic [DW-1:0] res,
  output logic          cy,
  output logic          ac,
  output logic          ov
);
  localparam int NW = DW / 2;

  logic [DW:0] full;
  logic [NW:0] nib;

  always_comb begin
    if (sub) begin
      full = {1'b0, a} - {1'b0, b} - {{DW{1'b0}}, cin};
      nib  = {1'b0, a[NW-1:0]} - {1'b0, b[NW-1:0]} - {{NW{1'b0}}, cin};
      ov   = (a[DW-1] != b[DW-1]) && (full[DW-1] != a[DW-1]);
    end else begin
      full = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
      nib  = {1'b0, a[NW-1:0]} + {1'b0, b[NW-1:0]} + {{NW{1'b0}}, cin};
      ov   = (a[DW-1] == b[DW-1]) && (full[DW-1] != a[DW-1]);
    end
    res = full[DW-1:0];
    cy  = full[DW];
    ac  = nib[NW];
  end
endmodule

// File: rtl/accu_muldiv.sv
module accu_muldiv #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] prod_lo,
  output logic [DW-1:0] prod_hi,
  output logic [DW-1:0] quot,
  output logic [DW-1:0] rem,
  output logic          mul_ov,
  output logic          div_zero
);
  localparam int PW = 2 * DW;

  logic [PW-1:0] prod;
  logic [DW-1:0] divisor;

  always_comb begin
    prod     = {{DW{1'b0}}, a} * {{DW{1'b0}}, b};
    prod_lo  = prod[DW-1:0];
    prod_hi  = prod[PW-1:DW];
    mul_ov   = |prod_hi;
    div_zero = (b == '0);
    divisor  = div_zero ? {{(DW-1){1'b0}}, 1'b1} : b;
    quot     = div_zero ? a : (a / divisor);
    rem      = div_zero ? b : (a % divisor);
  end
endmodule

// File: rtl/accu_bank_map.sv
module accu_bank_map #(
  parameter int IDX_W  = 3,
  parameter int BANK_W = 2
) (
  input  logic [BANK_W-1:0]       bank,
  input  logic [IDX_W-1:0]        idx,
  output logic [BANK_W+IDX_W-1:0] addr
);
  assign addr = {bank, idx};
endmodule

// File: rtl/accu_psw.sv
module accu_psw
  import accu_pkg::*;
#(
  parameter int BANK_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arith_en,
  input  logic             ac_en,
  input  logic             arith_cy,
  input  logic             arith_ac,
  input  logic             arith_ov,
  input  logic             wr_en,
  input  logic [PSW_W-1:0] wr_data,
  input  logic             par_nx,
  output logic [PSW_W-1:0] psw
);
  logic              cy_q, ac_q, ua_q, ov_q, ub_q, par_q;
  logic [BANK_W-1:0] rs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cy_q  <= 1'b0;
      ac_q  <= 1'b0;
      ua_q  <= 1'b0;
      rs_q  <= '0;
      ov_q  <= 1'b0;
      ub_q  <= 1'b0;
      par_q <= 1'b0;
    end else begin
      if (wr_en) begin
        cy_q <= wr_data[PSW_CY];
        ac_q <= wr_data[PSW_AC];
        ua_q <= wr_data[PSW_UA];
        rs_q <= wr_data[PSW_RS_HI:PSW_RS_LO];
        ov_q <= wr_data[PSW_OV];
        ub_q <= wr_data[PSW_UB];
      end
      if (arith_en) begin
        cy_q <= arith_cy;
        ov_q <= arith_ov;
        if (ac_en) ac_q <= arith_ac;
      end
      par_q <= par_nx;
    end
  end

  assign psw = {cy_q, ac_q, ua_q, rs_q, ov_q, ub_q, par_q};

  // R10
  wr_only_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !arith_en) |=> (psw[PSW_W-1:1] == $past(wr_data[PSW_W-1:1])));

  // R10
  arith_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && arith_en) |=> (psw[PSW_CY] == $past(arith_cy)) && (psw[PSW_OV] == $past(arith_ov))
                            && (psw[PSW_UA] == $past(wr_data[PSW_UA])));

  // R4
  ac_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (arith_en && !ac_en && !wr_en) |=> $stable(psw[PSW_AC]));
endmodule

// File: rtl/accu_alu_top.sv
module accu_alu_top
  import accu_pkg::*;
#(
  parameter int DW     = 8,
  parameter int IDX_W  = 3,
  parameter int BANK_W = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    op_valid,
  input  logic [2:0]              op_code,
  input  logic [DW-1:0]           operand,
  input  logic                    psw_we,
  input  logic [PSW_W-1:0]        psw_wdata,
  input  logic [IDX_W-1:0]        reg_idx,
  output logic [DW-1:0]           acc_q,
  output logic [DW-1:0]           b_q,
  output logic [PSW_W-1:0]        psw_q,
  output logic [BANK_W+IDX_W-1:0] ram_addr
);
  localparam int AW = BANK_W + IDX_W;

  accu_op_e      op;
  logic [DW-1:0] as_res, m_lo, m_hi, d_quo, d_rem;
  logic          as_cy, as_ac, as_ov, m_ov, d_zero;
  logic          sub_sel, cin_sel;
  logic [DW-1:0] acc_nx, b_nx;
  logic          arith_en, ac_en, f_cy, f_ov;
  logic [AW-1:0] addr_w;

  assign op      = accu_op_e'(op_code);
  assign sub_sel = (op == OP_SUBB);
  assign cin_sel = (op == OP_ADD) ? 1'b0 : psw_q[PSW_CY];

  accu_addsub #(.DW(DW)) u_addsub (
    .a(acc_q), .b(operand), .sub(sub_sel), .cin(cin_sel),
    .res(as_res), .cy(as_cy), .ac(as_ac), .ov(as_ov)
  );

  accu_muldiv #(.DW(DW)) u_muldiv (
    .a(acc_q), .b(b_q), .prod_lo(m_lo), .prod_hi(m_hi),
    .quot(d_quo), .rem(d_rem), .mul_ov(m_ov), .div_zero(d_zero)
  );

  always_comb begin
    acc_nx   = acc_q;
    b_nx     = b_q;
    arith_en = 1'b0;
    ac_en    = 1'b0;
    f_cy     = 1'b0;
    f_ov     = 1'b0;
    if (op_valid) begin
      unique case (op)
        OP_ADD, OP_ADDC, OP_SUBB: begin
          acc_nx   = as_res;
          arith_en = 1'b1;
          ac_en    = 1'b1;
          f_cy     = as_cy;
          f_ov     = as_ov;
        end
        OP_MUL: begin
          acc_nx   = m_lo;
          b_nx     = m_hi;
          arith_en = 1'b1;
          f_ov     = m_ov;
        end
        OP_DIV: begin
          acc_nx   = d_quo;
          b_nx     = d_rem;
          arith_en = 1'b1;
          f_ov     = d_zero;
        end
        OP_LDA:  acc_nx = operand;
        OP_LDB:  b_nx   = operand;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      b_q   <= '0;
    end else begin
      acc_q <= acc_nx;
      b_q   <= b_nx;
    end
  end

  accu_psw #(.BANK_W(BANK_W)) u_psw (
    .clk(clk), .rst(rst),
    .arith_en(arith_en), .ac_en(ac_en),
    .arith_cy(f_cy), .arith_ac(as_ac), .arith_ov(f_ov),
    .wr_en(psw_we), .wr_data(psw_wdata),
    .par_nx(^acc_nx),
    .psw(psw_q)
  );

  accu_bank_map #(.IDX_W(IDX_W), .BANK_W(BANK_W)) u_bank (
    .bank(psw_q[PSW_RS_HI:PSW_RS_LO]), .idx(reg_idx), .addr(addr_w)
  );
  assign ram_addr = addr_w;

  // R8
  parity_chk: assert property (@(posedge clk) disable iff (rst)
    psw_q[PSW_PAR] == ^acc_q);

  // R7
  div_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_DIV && b_q == '0) |=>
      (acc_q == $past(acc_q)) && (b_q == $past(b_q)) && psw_q[PSW_OV] && !psw_q[PSW_CY]);

  // R6
  mul_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_MUL) |=> !psw_q[PSW_CY] && (psw_q[PSW_OV] == (b_q != '0)));

  // R12
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    ((!op_valid || op_code == OP_NOP) && !psw_we) |=>
      $stable(acc_q) && $stable(b_q) && $stable(psw_q));

  // R11
  load_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op_code == OP_LDA || op_code == OP_LDB) && !psw_we) |=>
      $stable(psw_q[PSW_W-1:1]));
endmodule

// File: tb/tb_accu_alu_top.sv
module tb_accu_alu_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       op_valid = 1'b0;
  logic [2:0] op_code = 3'd7;
  logic [7:0] operand = 8'd0;
  logic       psw_we = 1'b0;
  logic [7:0] psw_wdata = 8'd0;
  logic [2:0] reg_idx = 3'd0;
  logic [7:0] acc_q, b_q, psw_q;
  logic [4:0] ram_addr;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [7:0] m_a = 8'd0, m_b = 8'd0, m_p = 8'd0;

  always #4 clk = ~clk;

  accu_alu_top dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .operand(operand), .psw_we(psw_we), .psw_wdata(psw_wdata),
    .reg_idx(reg_idx), .acc_q(acc_q), .b_q(b_q), .psw_q(psw_q),
    .ram_addr(ram_addr)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int sgn(input int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  // Reference model of one clock edge
  task automatic model(input bit v, input int op, input int x, input bit we, input int wd);
    int a = m_a, b = m_b, c = m_p[7];
    int r, s;
    logic [7:0] p = m_p;
    if (we) p[7:1] = wd[7:1];
    if (v) begin
      case (op)
        0, 1: begin
          if (op == 0) c = 0;
          r = a + x + c;
          s = sgn(a) + sgn(x) + c;
          p[7] = (r > 255);
          p[6] = ((a % 16) + (x % 16) + c) > 15;
          p[2] = (s > 127) || (s < -128);
          a = r % 256;
        end
        2: begin
          r = a - x - c;
          s = sgn(a) - sgn(x) - c;
          p[7] = (r < 0);
          p[6] = ((a % 16) - (x % 16) - c) < 0;
          p[2] = (s > 127) || (s < -128);
          a = (r + 256) % 256;
        end
        3: begin
          r = a * b;
          p[7] = 1'b0;
          p[2] = (r > 255);
          a = r % 256;
          b = r / 256;
        end
        4: begin
          p[7] = 1'b0;
          if (b == 0) p[2] = 1'b1;
          else begin
            p[2] = 1'b0;
            r = a / b;
            s = a % b;
            a = r;
            b = s;
          end
        end
        5: a = x;
        6: b = x;
        default: ;
      endcase
    end
    m_a = a[7:0];
    m_b = b[7:0];
    p[0] = ^m_a;
    m_p = p;
  endtask

  function automatic string req_of(input bit v, input int op);
    if (!v || op == 7) return "R12";
    case (op)
      0, 1: return "R2";
      2: return "R3";
      3: return "R6";
      4: return "R7";
      default: return "R11";
    endcase
  endfunction

  // Called at a falling edge: drive, pass one rising edge, check at next falling edge
  task automatic step(input bit v, input int op, input int x, input bit we, input int wd, input int idx);
    string rq = req_of(v, op);
    op_valid  = v;
    op_code   = op[2:0];
    operand   = x[7:0];
    psw_we    = we;
    psw_wdata = wd[7:0];
    reg_idx   = idx[2:0];
    model(v, op, x, we, wd);
    @(negedge clk);
    chk({rq, " acc"}, acc_q, m_a);
    chk({rq, " b"}, b_q, m_b);
    chk({rq, "/R4/R5/R10 psw"}, psw_q, m_p);
    chk("R8 parity", psw_q[0], ^m_a);
    chk("R9 ram_addr", ram_addr, {m_p[4:3], idx[2:0]});
  endtask

  initial begin
    void'($urandom(32'h0000_51C0));
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1 acc", acc_q, 0);
    chk("R1 b", b_q, 0);
    chk("R1 psw", psw_q, 0);
    rst = 1'b0;

    // R2: 0xFF + 0x01 carries, half-carries, no signed overflow
    step(1, 5, 8'hFF, 0, 0, 0);
    step(1, 0, 8'h01, 0, 0, 1);
    // R2: add with carry uses stored carry (0 + 0 + 1)
    step(1, 1, 8'h00, 0, 0, 2);
    // R5: 0x7F + 1 signed overflow
    step(1, 5, 8'h7F, 0, 0, 3);
    step(1, 0, 8'h01, 0, 0, 4);
    // R3: 0x80 - 1 with borrow clear: overflow; then 0 - 1 borrows
    step(1, 5, 8'h80, 0, 0, 5);
    step(1, 2, 8'h01, 0, 0, 6);
    step(1, 5, 8'h00, 0, 0, 7);
    step(1, 2, 8'h01, 0, 0, 0);
    // R4: half-borrow with subtract, borrow-in from stored carry
    step(1, 5, 8'h10, 0, 0, 0);
    step(1, 2, 8'h00, 0, 0, 1);
    // R6: 16 * 16 = 256, overflow; 15 * 17 = 255, no overflow
    step(1, 5, 8'd16, 0, 0, 0);
    step(1, 6, 8'd16, 0, 0, 0);
    step(1, 3, 0, 0, 0, 0);
    step(1, 5, 8'd15, 0, 0, 0);
    step(1, 6, 8'd17, 0, 0, 0);
    step(1, 3, 0, 0, 0, 0);
    // R7: 200 / 7, then divide by zero keeps registers
    step(1, 5, 8'd200, 0, 0, 0);
    step(1, 6, 8'd7, 0, 0, 0);
    step(1, 4, 0, 0, 0, 0);
    step(1, 6, 8'd0, 0, 0, 0);
    step(1, 4, 0, 0, 0, 0);
    // R8/R10: direct write with bit 0 set is ignored for parity; all banks (R9)
    step(0, 7, 0, 1, 8'hFF, 5);
    step(0, 7, 0, 1, 8'h09, 2);
    step(0, 7, 0, 1, 8'h11, 7);
    step(0, 7, 0, 1, 8'h00, 3);
    // R10: collision, arithmetic flags win, bank and user flags from write
    step(1, 5, 8'h01, 0, 0, 0);
    step(1, 0, 8'h01, 1, 8'hFE, 6);
    // R11: loads keep flags
    step(1, 5, 8'hA5, 0, 0, 0);
    step(1, 6, 8'h3C, 0, 0, 0);
    // R12: idle and code 7
    step(0, 0, 8'h55, 0, 0, 1);
    step(1, 7, 8'h55, 0, 0, 2);

    // Random mix
    for (int i = 0; i < 1500; i++) begin
      int op = $urandom % 8;
      int x = $urandom % 256;
      bit v = ($urandom % 8) != 0;
      bit we = ($urandom % 5) == 0;
      if (op == 6 && ($urandom % 4) == 0) x = 0;
      step(v, op, x, we, $urandom % 256, $urandom % 8);
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule